// File: doc/BRIEF.md
# TCP Connection Tracking Stage

This block sits behind a stateless rule filter and remembers which TCP connections have already been approved. Each request carries a packet's address and port 4-tuple, its TCP flag byte and the verdict the rule filter produced for it. A tuple that is already tracked is passed on the strength of the table alone. An untracked tuple takes the rule verdict. An approved connection-opening packet is recorded so that the rest of that connection no longer depends on the rule set.

Tracked entries hold only the tuple and one state bit, half-open or established. Closing or aborting packets free their entry at runtime. The number of half-open entries is reported continuously and drives a flood flag. A burst of opening handshakes that never complete therefore becomes visible without any extra storage.

Top module: `conn_tracker`

## Requirements
- R1: Every request sampled on a rising edge yields exactly one response, with resp_valid_o high for one cycle after the second rising edge from the sampling edge. Requests may arrive on consecutive cycles, and each request sees every table change made by the request before it.
- R2: A request whose 4-tuple equals a tracked entry, in the stored orientation or with source and destination (address and port) swapped, gets hit_o=1 and pass_o=1 whatever the rule verdict.
- R3: A request that matches no tracked entry gets hit_o=0 and pass_o equal to rule_allow_i.
- R4: A request that misses, has rule_allow_i=1, SYN (tcp_flags_i bit 1) set and ACK (bit 4) clear is installed as a half-open entry when a free slot exists. No other missing request changes the table.
- R5: A request that hits with SYN, FIN (bit 0) and RST (bit 2) all clear marks the entry established. A hitting request with SYN set and FIN and RST clear leaves the entry state unchanged.
- R6: A request that hits with FIN or RST set is passed and frees its entry, so the next request on that tuple misses.
- R7: table_full_o is high exactly while every slot is occupied. An allowed opening request that arrives then is still passed but is not installed.
- R8: half_open_o equals the number of tracked half-open entries, and syn_flood_o is high exactly while that number is at least FLOOD_THR. Both reflect a request's table change from the same edge as its response.
- R9: After reset the table is empty, and resp_valid_o, table_full_o, syn_flood_o and half_open_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| src_ip_i | input | 32 | Source address |
| dst_ip_i | input | 32 | Destination address |
| src_port_i | input | 16 | Source port |
| dst_port_i | input | 16 | Destination port |
| tcp_flags_i | input | 8 | TCP flag byte: bit0 FIN, bit1 SYN, bit2 RST, bit4 ACK |
| rule_allow_i | input | 1 | Rule filter verdict, 1 permits |
| resp_valid_o | output | 1 | Response strobe |
| pass_o | output | 1 | Packet may be forwarded |
| hit_o | output | 1 | Tuple was found in the table |
| table_full_o | output | 1 | All slots occupied |
| half_open_o | output | $clog2(ENTRIES+1) | Count of half-open entries |
| syn_flood_o | output | 1 | Half-open count at or above FLOOD_THR |

## Verification
The bench targets the reply direction of a tuple: a design that compared only the stored orientation would drop the server's SYN-ACK and fail to complete the handshake. The table is filled to capacity so that an overflow install, which would overwrite a live entry, shows up as a lost hit later. The flood threshold is crossed in both directions through opens, completions and resets, so an off-by-one in the compare would move the flag one request early or late. Back-to-back requests on one tuple expose a pipeline that lets the second request read the table before the first request's install.

// File: rtl/ct_pkg.sv
package ct_pkg;

  typedef struct packed {
    logic [31:0] src_ip;
    logic [31:0] dst_ip;
    logic [15:0] src_port;
    logic [15:0] dst_port;
  } tuple_t;

  localparam int unsigned FLAG_FIN = 0;
  localparam int unsigned FLAG_SYN = 1;
  localparam int unsigned FLAG_RST = 2;
  localparam int unsigned FLAG_ACK = 4;

  function automatic tuple_t tuple_swap(tuple_t t);
    tuple_t r;
    r.src_ip   = t.dst_ip;
    r.dst_ip   = t.src_ip;
    r.src_port = t.dst_port;
    r.dst_port = t.src_port;
    return r;
  endfunction

endpackage

// File: rtl/ct_match_array.sv
module ct_match_array
  import ct_pkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  tuple_t                       key_i,
  input  tuple_t [ENTRIES-1:0]         ent_i,
  input  logic   [ENTRIES-1:0]         valid_i,
  output logic                         hit_o,
  output logic [$clog2(ENTRIES)-1:0]   hit_idx_o,
  output logic                         free_o,
  output logic [$clog2(ENTRIES)-1:0]   free_idx_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  tuple_t               key_rev;
  logic [ENTRIES-1:0]   match;

  assign key_rev = tuple_swap(key_i);

  // one comparator pair per slot, both orientations of the tuple
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && ((ent_i[g] == key_i) || (ent_i[g] == key_rev));
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    free_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  assign hit_o  = |match;
  assign free_o = ~&valid_i;

endmodule

// File: rtl/ct_table.sv
module ct_table
  import ct_pkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ins_i,
  input  logic [$clog2(ENTRIES)-1:0] ins_idx_i,
  input  tuple_t                     ins_key_i,
  input  logic                       est_i,
  input  logic                       rel_i,
  input  logic [$clog2(ENTRIES)-1:0] hit_idx_i,
  output tuple_t [ENTRIES-1:0]       ent_o,
  output logic   [ENTRIES-1:0]       valid_o,
  output logic   [ENTRIES-1:0]       est_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic ins_here, est_here, rel_here;
    assign ins_here = ins_i && (ins_idx_i == IDX_W'(g));
    assign est_here = est_i && (hit_idx_i == IDX_W'(g));
    assign rel_here = rel_i && (hit_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        est_o[g]   <= 1'b0;
        ent_o[g]   <= '0;
      end else if (ins_here) begin
        valid_o[g] <= 1'b1;
        est_o[g]   <= 1'b0;
        ent_o[g]   <= ins_key_i;
      end else if (rel_here) begin
        valid_o[g] <= 1'b0;
        est_o[g]   <= 1'b0;
      end else if (est_here) begin
        est_o[g]   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ct_flood.sv
module ct_flood #(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned FLOOD_THR = 8
) (
  input  logic [ENTRIES-1:0]           valid_i,
  input  logic [ENTRIES-1:0]           est_i,
  output logic [$clog2(ENTRIES+1)-1:0] count_o,
  output logic                         flood_o
);
  localparam int unsigned CNT_W = $clog2(ENTRIES + 1);

  always_comb begin
    count_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      count_o = count_o + CNT_W'(valid_i[i] & ~est_i[i]);
    end
  end

  assign flood_o = ({1'b0, count_o} >= (CNT_W + 1)'(FLOOD_THR));

endmodule

// File: rtl/conn_tracker.sv
module conn_tracker
  import ct_pkg::*;
#(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned FLOOD_THR = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  input  logic [31:0]                    src_ip_i,
  input  logic [31:0]                    dst_ip_i,
  input  logic [15:0]                    src_port_i,
  input  logic [15:0]                    dst_port_i,
  input  logic [7:0]                     tcp_flags_i,
  input  logic                           rule_allow_i,
  output logic                           resp_valid_o,
  output logic                           pass_o,
  output logic                           hit_o,
  output logic                           table_full_o,
  output logic [$clog2(ENTRIES+1)-1:0]   half_open_o,
  output logic                           syn_flood_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  // stage 1: request register
  logic       req_q;
  tuple_t     key_q;
  logic [7:0] flags_q;
  logic       allow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      key_q   <= '0;
      flags_q <= '0;
      allow_q <= 1'b0;
    end else begin
      req_q <= req_valid_i;
      if (req_valid_i) begin
        key_q   <= '{src_ip: src_ip_i, dst_ip: dst_ip_i,
                     src_port: src_port_i, dst_port: dst_port_i};
        flags_q <= tcp_flags_i;
        allow_q <= rule_allow_i;
      end
    end
  end

  tuple_t [ENTRIES-1:0] ent;
  logic   [ENTRIES-1:0] valid;
  logic   [ENTRIES-1:0] est;
  logic                 hit, free;
  logic [IDX_W-1:0]     hit_idx, free_idx;

  ct_match_array #(.ENTRIES(ENTRIES)) u_match (
    .key_i     (key_q),
    .ent_i     (ent),
    .valid_i   (valid),
    .hit_o     (hit),
    .hit_idx_o (hit_idx),
    .free_o    (free),
    .free_idx_o(free_idx)
  );

  // stage 2: decision
  logic f_syn, f_ack, f_fin, f_rst;
  logic do_ins, do_est, do_rel, verdict;

  assign f_syn = flags_q[FLAG_SYN];
  assign f_ack = flags_q[FLAG_ACK];
  assign f_fin = flags_q[FLAG_FIN];
  assign f_rst = flags_q[FLAG_RST];

  assign do_ins  = req_q && !hit && allow_q && f_syn && !f_ack && free;
  assign do_rel  = req_q && hit && (f_fin || f_rst);
  assign do_est  = req_q && hit && !f_fin && !f_rst && !f_syn;
  assign verdict = hit || allow_q;

  ct_table #(.ENTRIES(ENTRIES)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ins_i    (do_ins),
    .ins_idx_i(free_idx),
    .ins_key_i(key_q),
    .est_i    (do_est),
    .rel_i    (do_rel),
    .hit_idx_i(hit_idx),
    .ent_o    (ent),
    .valid_o  (valid),
    .est_o    (est)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      pass_o       <= 1'b0;
      hit_o        <= 1'b0;
    end else begin
      resp_valid_o <= req_q;
      if (req_q) begin
        pass_o <= verdict;
        hit_o  <= hit;
      end
    end
  end

  ct_flood #(.ENTRIES(ENTRIES), .FLOOD_THR(FLOOD_THR)) u_flood (
    .valid_i(valid),
    .est_i  (est),
    .count_o(half_open_o),
    .flood_o(syn_flood_o)
  );

  assign table_full_o = &valid;

endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned FLOOD_THR = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_valid_i,
  input logic                           resp_valid_o,
  input logic                           pass_o,
  input logic                           hit_o,
  input logic                           table_full_o,
  input logic [$clog2(ENTRIES+1)-1:0]   half_open_o,
  input logic                           syn_flood_o
);
  localparam int unsigned CW = $clog2(ENTRIES + 1);
  localparam logic [CW:0] THR_C = (CW + 1)'(FLOOD_THR);
  localparam logic [CW:0] ENT_C = (CW + 1)'(ENTRIES);

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ##1 resp_valid_o);

  assert_no_spurious_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ##1 !resp_valid_o);

  assert_hit_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && hit_o) |-> pass_o);

  assert_idle_state_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> ($stable(half_open_o) && $stable(table_full_o)));

  assert_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, half_open_o} <= ENT_C);

  assert_flood_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(syn_flood_o) |-> ({1'b0, half_open_o} >= THR_C));

  assert_flood_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(syn_flood_o) |-> ({1'b0, half_open_o} < THR_C));

  assert_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (({1'b0, half_open_o} <= {1'b0, $past(half_open_o)} + 1'b1) &&
     ({1'b0, $past(half_open_o)} <= {1'b0, half_open_o} + 1'b1)));

endmodule

bind conn_tracker ct_checker #(.ENTRIES(ENTRIES), .FLOOD_THR(FLOOD_THR)) u_ct_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .resp_valid_o(resp_valid_o),
  .pass_o      (pass_o),
  .hit_o       (hit_o),
  .table_full_o(table_full_o),
  .half_open_o (half_open_o),
  .syn_flood_o (syn_flood_o)
);

// File: tb/tb_conn_tracker.sv
module tb_conn_tracker;
  import ct_pkg::*;

  localparam int N   = 4;
  localparam int THR = 3;
  localparam int CW  = $clog2(N + 1);

  localparam logic [7:0] F_SYN    = 8'h02;
  localparam logic [7:0] F_SYNACK = 8'h12;
  localparam logic [7:0] F_ACK    = 8'h10;
  localparam logic [7:0] F_FINACK = 8'h11;
  localparam logic [7:0] F_RST    = 8'h04;
  localparam logic [7:0] F_PSHACK = 8'h18;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [31:0] src_ip_i = '0, dst_ip_i = '0;
  logic [15:0] src_port_i = '0, dst_port_i = '0;
  logic [7:0]  tcp_flags_i = '0;
  logic        rule_allow_i = 1'b0;
  logic        resp_valid_o, pass_o, hit_o, table_full_o, syn_flood_o;
  logic [CW-1:0] half_open_o;

  always #2 clk = ~clk;

  conn_tracker #(.ENTRIES(N), .FLOOD_THR(THR)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .src_ip_i(src_ip_i), .dst_ip_i(dst_ip_i), .src_port_i(src_port_i),
    .dst_port_i(dst_port_i), .tcp_flags_i(tcp_flags_i),
    .rule_allow_i(rule_allow_i), .resp_valid_o(resp_valid_o), .pass_o(pass_o),
    .hit_o(hit_o), .table_full_o(table_full_o), .half_open_o(half_open_o),
    .syn_flood_o(syn_flood_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tuple_t m_t [N];
  bit     m_v [N];
  bit     m_e [N];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic tuple_t mk(int a, bit rev);
    tuple_t t;
    t.src_ip   = 32'h0a00_0000 + 32'(a);
    t.dst_ip   = 32'hc0a8_0000 + 32'(a % 3);
    t.src_port = 16'(1024 + a);
    t.dst_port = 16'(80 + (a % 2));
    return rev ? tuple_swap(t) : t;
  endfunction

  function automatic int mfind(tuple_t t);
    for (int i = 0; i < N; i++)
      if (m_v[i] && (m_t[i] == t || m_t[i] == tuple_swap(t))) return i;
    return -1;
  endfunction

  task automatic model(tuple_t t, logic [7:0] f, logic al, output logic ep, output logic eh);
    int idx;
    idx = mfind(t);
    if (idx >= 0) begin
      ep = 1; eh = 1;
      if (f[0] || f[2]) m_v[idx] = 0;
      else if (!f[1]) m_e[idx] = 1;
    end else begin
      ep = al; eh = 0;
      if (al && f[1] && !f[4]) begin
        for (int i = 0; i < N; i++)
          if (!m_v[i]) begin
            m_v[i] = 1; m_e[i] = 0; m_t[i] = t;
            break;
          end
      end
    end
  endtask

  task automatic chk_state();
    int ho;
    bit full;
    ho = 0; full = 1;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && !m_e[i]) ho++;
      if (!m_v[i]) full = 0;
    end
    chk("R8 half_open", 32'(half_open_o), 32'(ho));
    chk("R8 syn_flood", 32'(syn_flood_o), 32'(ho >= THR));
    chk("R7 table_full", 32'(table_full_o), 32'(full));
  endtask

  task automatic drive(tuple_t t, logic [7:0] f, logic al);
    req_valid_i = 1; src_ip_i = t.src_ip; dst_ip_i = t.dst_ip;
    src_port_i = t.src_port; dst_port_i = t.dst_port;
    tcp_flags_i = f; rule_allow_i = al;
  endtask

  task automatic pkt(tuple_t t, logic [7:0] f, logic al, output logic ap, output logic ah);
    logic ep, eh;
    @(negedge clk); drive(t, f, al);
    @(negedge clk); req_valid_i = 0;
    chk("R1 no early response", 32'(resp_valid_o), 32'h0);
    model(t, f, al, ep, eh);
    @(negedge clk);
    chk("R1 response valid", 32'(resp_valid_o), 32'h1);
    chk(eh ? "R2 hit" : "R3 miss hit flag", 32'(hit_o), 32'(eh));
    chk(eh ? "R2 pass" : "R3 rule verdict", 32'(pass_o), 32'(ep));
    chk_state();
    ap = pass_o; ah = hit_o;
  endtask

  task automatic do_reset();
    rst_ni = 0; req_valid_i = 0;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_e[i] = 0; m_t[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic p, h;
    logic [31:0] lf;
    do_reset();
    // R9 reset state
    chk("R9 resp_valid", 32'(resp_valid_o), 32'h0);
    chk("R9 table_full", 32'(table_full_o), 32'h0);
    chk("R9 syn_flood", 32'(syn_flood_o), 32'h0);
    chk("R9 half_open", 32'(half_open_o), 32'h0);

    // R3: denied miss passes nothing, not installed
    pkt(mk(0, 0), F_SYN, 1'b0, p, h);
    chk("R3 denied", 32'(p), 32'h0);
    chk("R4 denied not installed", 32'(half_open_o), 32'h0);
    // R4: allowed SYN-ACK miss not installed
    pkt(mk(0, 0), F_SYNACK, 1'b1, p, h);
    chk("R4 synack not installed", 32'(half_open_o), 32'h0);

    // R4/R8: install three half-open, flag rises at threshold
    pkt(mk(1, 0), F_SYN, 1'b1, p, h);
    pkt(mk(2, 0), F_SYN, 1'b1, p, h);
    chk("R8 below threshold", 32'(syn_flood_o), 32'h0);
    pkt(mk(3, 0), F_SYN, 1'b1, p, h);
    chk("R8 flood at threshold", 32'(syn_flood_o), 32'h1);
    // R2: reply direction hits despite deny; SYN-ACK keeps half-open (R5)
    pkt(mk(1, 1), F_SYNACK, 1'b0, p, h);
    chk("R2 reverse hit", 32'(h), 32'h1);
    chk("R5 synack keeps half-open", 32'(half_open_o), 32'h3);
    // R5: ACK establishes, flag falls
    pkt(mk(1, 0), F_ACK, 1'b0, p, h);
    chk("R5 established", 32'(half_open_o), 32'h2);
    chk("R8 flood cleared", 32'(syn_flood_o), 32'h0);
    // R7: fill then overflow
    pkt(mk(4, 0), F_SYN, 1'b1, p, h);
    chk("R7 full", 32'(table_full_o), 32'h1);
    pkt(mk(5, 0), F_SYN, 1'b1, p, h);
    chk("R7 overflow passed", 32'(p), 32'h1);
    pkt(mk(5, 0), F_ACK, 1'b0, p, h);
    chk("R7 overflow not installed", 32'(h), 32'h0);
    // R6: FIN frees, next packet misses
    pkt(mk(1, 1), F_FINACK, 1'b0, p, h);
    chk("R6 fin passed", 32'(p), 32'h1);
    chk("R6 slot freed", 32'(table_full_o), 32'h0);
    pkt(mk(1, 0), F_ACK, 1'b0, p, h);
    chk("R6 freed tuple misses", 32'(h), 32'h0);
    // R6: RST on half-open frees it
    pkt(mk(2, 0), F_RST, 1'b0, p, h);
    chk("R6 rst frees half-open", 32'(half_open_o), 32'h2);

    // R1: back-to-back install then data on same tuple
    do_reset();
    @(negedge clk); drive(mk(7, 0), F_SYN, 1'b1);
    @(negedge clk); drive(mk(7, 1), F_PSHACK, 1'b0);
    @(negedge clk); req_valid_i = 0;
    chk("R1 b2b first valid", 32'(resp_valid_o), 32'h1);
    chk("R1 b2b first pass", 32'(pass_o), 32'h1);
    chk("R1 b2b first miss", 32'(hit_o), 32'h0);
    @(negedge clk);
    chk("R1 b2b second valid", 32'(resp_valid_o), 32'h1);
    chk("R1 b2b second hit", 32'(hit_o), 32'h1);
    chk("R1 b2b second pass", 32'(pass_o), 32'h1);
    chk("R5 b2b established", 32'(half_open_o), 32'h0);
    @(negedge clk);
    chk("R1 single response", 32'(resp_valid_o), 32'h0);

    // sweep: pseudo-random traffic over a small tuple pool against the model
    do_reset();
    lf = 32'h1234_5678;
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] f;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      case (lf[2:0])
        3'd0, 3'd1: f = F_SYN;
        3'd2: f = F_SYNACK;
        3'd3: f = F_ACK;
        3'd4: f = F_FINACK;
        3'd5: f = F_RST;
        3'd6: f = F_PSHACK;
        default: f = lf[15:8];
      endcase
      pkt(mk(int'(lf[19:16]) % 7, lf[20]), f, lf[23:21] != 3'd0, p, h);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule